// File: doc/BRIEF.md
# Packed-Lane Vector Bit-Manipulation Unit

This unit applies one bit-manipulation operation to every element packed into a 64-bit lane word. The element width is chosen per beat as 8, 16, 32 or 64 bits, so a lane carries eight, four, two or one independent elements. The operations are rotate left, rotate right, reversal of the bit order inside each byte, reversal of the byte order inside each element, and and-not. No bit ever crosses an element boundary.

The second operand of each element has one of three sources. It can be the matching element of a second vector word. It can be a scalar, which is sign-extended or truncated to the element width and copied into every element. It can be a small unsigned immediate, which is zero-extended into every element and is honoured only by rotate right. Rotations use only the low log2(SEW) bits of that operand.

Beats enter and leave through valid/ready handshakes, with one register stage in between. A beat is accepted when `in_valid` and `in_ready` are both high. Its result appears on `out_data` with `out_valid` on the next clock. While `out_valid` is high and `out_ready` is low, the output holds and `in_ready` stays low, so back-pressure reaches the producer in the same cycle. When the consumer takes a result, a new beat can be accepted in that same cycle.

Top module: `vbm_lane_alu`

## Requirements
- R1: `in_ready` is high whenever `out_valid` is low or `out_ready` is high. A beat accepted at a clock edge shows on `out_data` with `out_valid` high after that edge. `out_valid` falls after an edge where the result is taken and no new beat is accepted.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold and `in_ready` is low. When the result is taken, a beat offered in the same cycle is accepted.
- R3: After reset, `out_valid` is low and `in_ready` is high.
- R4: `in_sew` codes 0, 1, 2 and 3 select element widths of 8, 16, 32 and 64 bits. Element k occupies lane bits [k*SEW +: SEW], and each element's result depends only on that element's operands.
- R5: Op code 0 rotates each `in_vs2` element left by the element's amount.
- R6: Op code 1 rotates each `in_vs2` element right by the element's amount.
- R7: The rotate amount is the low log2(SEW) bits of the operand element, and all higher bits are ignored. An amount of zero, or any multiple of SEW, returns the element unchanged.
- R8: Op code 2 reverses the bit order inside every byte and leaves the byte positions unchanged, whatever the element width.
- R9: Op code 3 reverses the byte order of each element. At SEW 8 it returns `in_vs2` unchanged.
- R10: Op code 4 returns `in_vs2 & ~operand` for each element.
- R11: Source code 1 takes `in_scalar`, sign-extended when it is narrower than the lane (or truncated), and uses its low SEW bits as the operand of every element.
- R12: Source code 2 uses `in_imm`, zero-extended to SEW, as the operand of every element, but only with op code 1. With any other op, source code 2 acts as source code 1. Source codes 0 and 3 take the operand from `in_vs1`.
- R13: Op codes 5, 6 and 7 pass `in_vs2` through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Unit can accept the offered beat |
| in_op | input | 3 | Operation code (0 rotl, 1 rotr, 2 bit-reverse bytes, 3 byte-reverse, 4 and-not) |
| in_sew | input | 2 | Element width code (0:8, 1:16, 2:32, 3:64) |
| in_src | input | 2 | Operand source (0 vector, 1 scalar, 2 immediate, 3 vector) |
| in_vs2 | input | LANE_W (64) | Lane word that is operated on |
| in_vs1 | input | LANE_W (64) | Vector operand lane word |
| in_scalar | input | SCALAR_W (64) | Scalar operand |
| in_imm | input | IMM_W (5) | Unsigned immediate operand |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | LANE_W (64) | Result lane word |

## Verification
The bench sweeps the rotate amount from 0 to 255 at every element width, in both directions. A design that masks the amount to the wrong width fails at amounts just past SEW. A design that lets bits leak between neighbouring elements fails with the mixed per-element patterns. It also crosses every op code with every source code and element width, using scalars that have the top bit both set and clear on a unit with a narrow scalar port. A design that zero-extends the scalar, or honours the immediate for operations other than rotate right, gives wrong 64-bit results. Stall tests hold `out_ready` low while a second beat waits. A unit that overwrote its register or kept `in_ready` high would lose or corrupt the first result.

// File: rtl/vbm_pkg.sv
package vbm_pkg;
  localparam int SEW_CNT = 4;
  localparam int BYTE_W  = 8;

  typedef enum logic [2:0] {
    OP_ROTL      = 3'd0,
    OP_ROTR      = 3'd1,
    OP_BITREV_B  = 3'd2,
    OP_BYTEREV   = 3'd3,
    OP_ANDNOT    = 3'd4
  } vbm_op_e;

  typedef enum logic [1:0] {
    SRC_VEC    = 2'd0,
    SRC_SCALAR = 2'd1,
    SRC_IMM    = 2'd2,
    SRC_ALT    = 2'd3
  } vbm_src_e;
endpackage

// File: rtl/vbm_operand_sel.sv
module vbm_operand_sel
  import vbm_pkg::*;
#(
  parameter int LANE_W   = 64,
  parameter int SCALAR_W = 64,
  parameter int IMM_W    = 5
) (
  input  logic [1:0]          sew,
  input  vbm_src_e            src,
  input  logic [LANE_W-1:0]   vec_op,
  input  logic [SCALAR_W-1:0] scalar,
  input  logic [IMM_W-1:0]    imm,
  output logic [LANE_W-1:0]   opnd
);
  logic [LANE_W-1:0] scalar_ext;
  logic [LANE_W-1:0] bc_scalar [SEW_CNT];
  logic [LANE_W-1:0] bc_imm    [SEW_CNT];

  // sign-extend a narrow scalar, truncate a wide one
  generate
    if (SCALAR_W >= LANE_W) begin : g_trunc
      assign scalar_ext = scalar[LANE_W-1:0];
    end else begin : g_sext
      assign scalar_ext = {{(LANE_W-SCALAR_W){scalar[SCALAR_W-1]}}, scalar};
    end
  endgenerate

  // broadcast scalar and immediate into every element, one copy per width
  generate
    for (genvar g = 0; g < SEW_CNT; g++) begin : g_sew
      localparam int EW = BYTE_W << g;
      localparam int NE = LANE_W / EW;
      logic [EW-1:0] imm_el;
      assign imm_el       = {{(EW-IMM_W){1'b0}}, imm};
      assign bc_scalar[g] = {NE{scalar_ext[EW-1:0]}};
      assign bc_imm[g]    = {NE{imm_el}};
    end
  endgenerate

  always_comb begin
    unique case (src)
      SRC_SCALAR: opnd = bc_scalar[sew];
      SRC_IMM:    opnd = bc_imm[sew];
      default:    opnd = vec_op;
    endcase
  end
endmodule

// File: rtl/vbm_rotator.sv
module vbm_rotator
  import vbm_pkg::*;
#(
  parameter int LANE_W = 64
) (
  input  logic [1:0]        sew,
  input  logic              to_right,
  input  logic [LANE_W-1:0] data,
  input  logic [LANE_W-1:0] amt,
  output logic [LANE_W-1:0] result
);
  logic [LANE_W-1:0] per_sew [SEW_CNT];
  logic              unused_amt;

  // bits above log2(SEW) in each amount element are ignored on purpose
  assign unused_amt = ^amt;

  generate
    for (genvar g = 0; g < SEW_CNT; g++) begin : g_sew
      localparam int EW  = BYTE_W << g;
      localparam int NE  = LANE_W / EW;
      localparam int SHW = $clog2(EW);
      logic [LANE_W-1:0] res_g;
      for (genvar e = 0; e < NE; e++) begin : g_el
        logic [EW-1:0]   x;
        logic [SHW-1:0]  sh;
        logic [2*EW-1:0] dbl;
        logic [2*EW-1:0] lft;
        logic [2*EW-1:0] rgt;
        logic            unused_half;
        assign x   = data[e*EW +: EW];
        assign sh  = amt[e*EW +: SHW];
        assign dbl = {x, x};
        assign lft = dbl << sh;
        assign rgt = dbl >> sh;
        assign unused_half = ^{lft[EW-1:0], rgt[2*EW-1:EW]};
        assign res_g[e*EW +: EW] = to_right ? rgt[EW-1:0] : lft[2*EW-1:EW];
      end
      assign per_sew[g] = res_g;
    end
  endgenerate

  assign result = per_sew[sew];
endmodule

// File: rtl/vbm_byte_perm.sv
module vbm_byte_perm
  import vbm_pkg::*;
#(
  parameter int LANE_W = 64
) (
  input  logic [1:0]        sew,
  input  logic [LANE_W-1:0] data,
  output logic [LANE_W-1:0] bitrev,
  output logic [LANE_W-1:0] byterev
);
  localparam int NBYTES = LANE_W / BYTE_W;
  logic [LANE_W-1:0] per_sew [SEW_CNT];

  // bit order inside each byte does not depend on element width
  generate
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
        assign bitrev[b*BYTE_W + i] = data[b*BYTE_W + BYTE_W-1-i];
      end
    end
  endgenerate

  // byte order inside each element, one wiring per width
  generate
    for (genvar g = 0; g < SEW_CNT; g++) begin : g_sew
      localparam int EW = BYTE_W << g;
      localparam int NE = LANE_W / EW;
      localparam int NB = EW / BYTE_W;
      logic [LANE_W-1:0] res_g;
      for (genvar e = 0; e < NE; e++) begin : g_el
        for (genvar k = 0; k < NB; k++) begin : g_b
          assign res_g[e*EW + k*BYTE_W +: BYTE_W] =
            data[e*EW + (NB-1-k)*BYTE_W +: BYTE_W];
        end
      end
      assign per_sew[g] = res_g;
    end
  endgenerate

  assign byterev = per_sew[sew];
endmodule

// File: rtl/vbm_lane_alu.sv
module vbm_lane_alu
  import vbm_pkg::*;
#(
  parameter int LANE_W   = 64,
  parameter int SCALAR_W = 64,
  parameter int IMM_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [2:0]          in_op,
  input  logic [1:0]          in_sew,
  input  logic [1:0]          in_src,
  input  logic [LANE_W-1:0]   in_vs2,
  input  logic [LANE_W-1:0]   in_vs1,
  input  logic [SCALAR_W-1:0] in_scalar,
  input  logic [IMM_W-1:0]    in_imm,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [LANE_W-1:0]   out_data
);
  vbm_src_e          src_eff;
  logic [LANE_W-1:0] opnd;
  logic [LANE_W-1:0] rot_res;
  logic [LANE_W-1:0] brev_res;
  logic [LANE_W-1:0] bswap_res;
  logic [LANE_W-1:0] result;
  logic              fire;

  // immediate is legal for rotate right only; elsewhere it means scalar
  always_comb begin
    unique case (in_src)
      SRC_SCALAR: src_eff = SRC_SCALAR;
      SRC_IMM:    src_eff = (in_op == OP_ROTR) ? SRC_IMM : SRC_SCALAR;
      default:    src_eff = SRC_VEC;
    endcase
  end

  vbm_operand_sel #(
    .LANE_W  (LANE_W),
    .SCALAR_W(SCALAR_W),
    .IMM_W   (IMM_W)
  ) u_opsel (
    .sew   (in_sew),
    .src   (src_eff),
    .vec_op(in_vs1),
    .scalar(in_scalar),
    .imm   (in_imm),
    .opnd  (opnd)
  );

  vbm_rotator #(.LANE_W(LANE_W)) u_rot (
    .sew     (in_sew),
    .to_right(in_op == OP_ROTR),
    .data    (in_vs2),
    .amt     (opnd),
    .result  (rot_res)
  );

  vbm_byte_perm #(.LANE_W(LANE_W)) u_perm (
    .sew    (in_sew),
    .data   (in_vs2),
    .bitrev (brev_res),
    .byterev(bswap_res)
  );

  always_comb begin
    case (in_op)
      OP_ROTL, OP_ROTR: result = rot_res;
      OP_BITREV_B:      result = brev_res;
      OP_BYTEREV:       result = bswap_res;
      OP_ANDNOT:        result = in_vs2 & ~opnd;
      default:          result = in_vs2;
    endcase
  end

  // single skid-free stage: ready while empty or while being drained
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
    end else if (fire) begin
      out_data <= result;
    end
  end
endmodule

// File: rtl/vbm_lane_alu_chk.sv
module vbm_lane_alu_chk
  import vbm_pkg::*;
#(
  parameter int LANE_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [2:0]        in_op,
  input logic [1:0]        in_sew,
  input logic [1:0]        in_src,
  input logic [LANE_W-1:0] in_vs2,
  input logic [LANE_W-1:0] in_vs1,
  input logic              out_valid,
  input logic              out_ready,
  input logic [LANE_W-1:0] out_data
);
  logic fire;
  assign fire = in_valid && in_ready;

  p_ready_when_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_accept_to_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  p_hold_on_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_zero_rotate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (in_op == OP_ROTL || in_op == OP_ROTR) && in_src == SRC_VEC && in_vs1 == '0)
      |=> (out_data == $past(in_vs2)));

  p_bitrev_popcount_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_op == OP_BITREV_B) |=> ($countones(out_data) == $countones($past(in_vs2))));

  p_byterev_sew8_identity_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_op == OP_BYTEREV && in_sew == 2'd0) |=> (out_data == $past(in_vs2)));

  p_andnot_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_op == OP_ANDNOT && in_src == SRC_VEC && in_vs1 == '0)
      |=> (out_data == $past(in_vs2)));
endmodule

bind vbm_lane_alu vbm_lane_alu_chk #(.LANE_W(LANE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_op    (in_op),
  .in_sew   (in_sew),
  .in_src   (in_src),
  .in_vs2   (in_vs2),
  .in_vs1   (in_vs1),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data)
);

// File: tb/vbm_lane_alu_bench.sv
`timescale 1ns/1ps
module vbm_lane_alu_bench;
  localparam int LW = 64;
  localparam int XW = 32;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [2:0]    in_op = '0;
  logic [1:0]    in_sew = '0;
  logic [1:0]    in_src = '0;
  logic [LW-1:0] in_vs2 = '0;
  logic [LW-1:0] in_vs1 = '0;
  logic [XW-1:0] in_scalar = '0;
  logic [IW-1:0] in_imm = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [LW-1:0] out_data;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  vbm_lane_alu #(.LANE_W(LW), .SCALAR_W(XW), .IMM_W(IW)) u_vbm_lane_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_sew(in_sew), .in_src(in_src), .in_vs2(in_vs2),
    .in_vs1(in_vs1), .in_scalar(in_scalar), .in_imm(in_imm),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(input logic ok, input string req,
                       input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // bit-level reference computed from the requirements
  function automatic logic [LW-1:0] model(input logic [2:0] op, input logic [1:0] sew,
      input logic [1:0] src, input logic [LW-1:0] vs2, input logic [LW-1:0] vs1,
      input logic [XW-1:0] sc, input logic [IW-1:0] imm);
    int ew;
    int ne;
    int s;
    logic [LW-1:0] sx;
    logic [LW-1:0] r;
    ew = 8 << sew;
    ne = LW / ew;
    sx = {{(LW-XW){sc[XW-1]}}, sc};
    s = int'(src);
    if (s == 2 && op != 3'd1) s = 1;
    if (s == 3) s = 0;
    r = '0;
    for (int e = 0; e < ne; e++) begin
      logic [63:0] a;
      logic [63:0] b;
      int amt;
      int nb;
      a = '0;
      b = '0;
      for (int i = 0; i < ew; i++) begin
        a[i] = vs2[e*ew + i];
        if (s == 0)       b[i] = vs1[e*ew + i];
        else if (s == 1)  b[i] = sx[i];
        else if (i < IW)  b[i] = imm[i];
        else              b[i] = 1'b0;
      end
      amt = int'(b[5:0]) % ew;
      nb = ew / 8;
      for (int i = 0; i < ew; i++) begin
        case (op)
          3'd0: r[e*ew + (i + amt) % ew] = a[i];
          3'd1: r[e*ew + i] = a[(i + amt) % ew];
          3'd2: r[e*ew + i] = a[(i / 8) * 8 + 7 - (i % 8)];
          3'd3: r[e*ew + i] = a[(nb - 1 - i / 8) * 8 + (i % 8)];
          3'd4: r[e*ew + i] = a[i] & ~b[i];
          default: r[e*ew + i] = a[i];
        endcase
      end
    end
    return r;
  endfunction

  function automatic logic [LW-1:0] pat_a(input int p);
    case (p % 6)
      0: return 64'h0123_4567_89AB_CDEF;
      1: return 64'h8000_0000_0000_0001;
      2: return 64'hA5A5_0F0F_3C3C_F00F;
      3: return 64'hFFFF_FFFF_FFFF_FFFF;
      4: return 64'h1E2D_3C4B_5A69_7887;
      default: return 64'hC001_D00D_0BAD_F1E5;
    endcase
  endfunction

  function automatic logic [LW-1:0] pat_b(input int p);
    case (p % 6)
      0: return 64'h0001_0203_0405_0607;
      1: return 64'hF0E1_D2C3_B4A5_9687;
      2: return 64'h0000_0000_0000_0000;
      3: return 64'h3F3E_2120_1F10_0908;
      4: return 64'h4140_C3C2_8584_0B0A;
      default: return 64'hFFFF_0000_FFFF_0000;
    endcase
  endfunction

  function automatic logic [XW-1:0] pat_s(input int p);
    case (p % 6)
      0: return 32'h8000_0003;
      1: return 32'h7FFF_FFF5;
      2: return 32'hFFFF_FFFF;
      3: return 32'h0000_0009;
      4: return 32'h1234_5678;
      default: return 32'hC0DE_0021;
    endcase
  endfunction

  function automatic string tags(input logic [2:0] op, input logic [1:0] src);
    string t;
    case (op)
      3'd0: t = "R5";
      3'd1: t = "R6";
      3'd2: t = "R8";
      3'd3: t = "R9";
      3'd4: t = "R10";
      default: t = "R13";
    endcase
    t = {t, " R4"};
    if (src == 2'd1 || (src == 2'd2 && op != 3'd1)) t = {t, " R11"};
    if (src == 2'd2 || src == 2'd3) t = {t, " R12"};
    return t;
  endfunction

  // one beat with out_ready high: drive at a falling edge, check one cycle later
  task automatic beat(input logic [2:0] op, input logic [1:0] sew, input logic [1:0] src,
                      input logic [LW-1:0] vs2, input logic [LW-1:0] vs1,
                      input logic [XW-1:0] sc, input logic [IW-1:0] imm, input string req);
    logic [LW-1:0] exp;
    exp = model(op, sew, src, vs2, vs1, sc, imm);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_sew = sew; in_src = src;
    in_vs2 = vs2; in_vs1 = vs1; in_scalar = sc; in_imm = imm;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_data == exp, req, out_data, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [LW-1:0] ea;
    logic [LW-1:0] eb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3: empty after reset
    check(!out_valid && in_ready, "R3", {62'd0, out_valid, in_ready}, 64'd1);

    // R1: a single beat appears after one edge, then the stage drains
    beat(3'd0, 2'd0, 2'd0, pat_a(0), pat_b(0), pat_s(0), 5'd0, "R1 R5");
    @(negedge clk);
    check(!out_valid && in_ready, "R1", {62'd0, out_valid, in_ready}, 64'd1);

    // R2: stall holds the first result, second beat waits
    ea = model(3'd3, 2'd2, 2'd0, pat_a(2), '0, '0, '0);
    eb = model(3'd1, 2'd1, 2'd2, pat_a(4), '0, pat_s(1), 5'd7);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 3'd3; in_sew = 2'd2; in_src = 2'd0;
    in_vs2 = pat_a(2); in_vs1 = '0; in_scalar = '0; in_imm = '0;
    @(negedge clk);
    in_op = 3'd1; in_sew = 2'd1; in_src = 2'd2;
    in_vs2 = pat_a(4); in_scalar = pat_s(1); in_imm = 5'd7;
    check(out_valid && !in_ready && out_data == ea, "R2", out_data, ea);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(out_valid && !in_ready && out_data == ea, "R2", out_data, ea);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_data == eb, "R2 R12", out_data, eb);
    @(negedge clk);
    check(!out_valid, "R1", {63'd0, out_valid}, 64'd0);

    // R4..R13: every op, source and width across operand patterns
    for (int sw = 0; sw < 4; sw++)
      for (int op = 0; op < 8; op++)
        for (int src = 0; src < 4; src++)
          for (int p = 0; p < 6; p++)
            beat(3'(op), 2'(sw), 2'(src), pat_a(p + op), pat_b(p + src),
                 pat_s(p + sw), 5'((p * 7 + op * 3 + 1) % 32),
                 tags(3'(op), 2'(src)));

    // R7: amount sweep incl. zero, multiples of SEW and ignored high bits
    for (int sw = 0; sw < 4; sw++)
      for (int op = 0; op < 2; op++)
        for (int v = 0; v < 256; v++)
          beat(3'(op), 2'(sw), 2'd0, pat_a(v), {8{8'(v)}}, '0, '0, "R7 R4");

    // R7 R12: immediate amounts for rotate right
    for (int sw = 0; sw < 4; sw++)
      for (int v = 0; v < 32; v++)
        beat(3'd1, 2'(sw), 2'd2, pat_a(v + 1), pat_b(v), pat_s(v), 5'(v), "R7 R12 R6");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule